// File: doc/BRIEF.md
# Keyed Nonvolatile Byte Store Controller

This block sits between a CPU register bus and a small byte-addressable data array that stands in for on-chip nonvolatile storage. Software sees four byte-wide registers: a control register, an address register, a data register and a write-only key register. Software reads a byte by loading the address and setting a one-shot read bit. The byte then appears in the data register on the next clock.

Writing a byte is guarded. Software first loads the address and the data and sets the write-enable bit. It then writes the two key values to the key register and sets the write-start bit, with the three steps back to back. Only then does a self-timed write begin. The write lasts a fixed, parameterised number of clock cycles and commits the byte when the count ends. At that point the write-start bit drops and a sticky completion flag is raised. An interrupt output follows that flag when software has enabled it.

Top module: `nvb_ctrl`

## Requirements
- R1: After reset the control, address and data registers read 0, `irq` is low and no write is in progress.
- R2: A bus write to offset 0 with bit 0 set, while no write is in progress, loads the data register (offset 2) with the array byte at the address register (offset 1). The new value is readable from the next clock. Bit 0 always reads back 0.
- R3: The data register keeps its value until another read is requested or the CPU writes offset 2. Changing the address register alone does not alter it.
- R4: A write starts only on this exact sequence of bus writes: 8'h55 to the key register (offset 3), then 8'hAA to it, then a control write with bit 2 set. At most one idle bus cycle may fall between two steps. A wrong value, a different order, any other bus access in between, or a gap of two or more idle cycles means no write occurs.
- R5: A write cannot start unless the write-enable bit (control bit 1) was already set before the write-start control write.
- R6: A started write keeps control bits 2 (write active) and 5 (busy) at 1 for exactly WRITE_CYCLES clock cycles. It then commits the byte to the array, clears bit 2 and sets the completion flag (control bit 3).
- R7: Hardware never clears the write-enable bit. Clearing it by software during a write does not abort that write.
- R8: While a write is in progress, bus writes to the address and data registers and read requests have no effect.
- R9: The completion flag is cleared only by a control write with bit 3 at 0. Writing 1 to bit 3 keeps it, and idle time never clears it.
- R10: `irq` is high exactly when the completion flag and the interrupt-enable bit (control bit 4) are both set.
- R11: The key sequence is needed for every byte. A write-start after a completed write, without a fresh key sequence, starts no write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Bus access strobe, one access per cycle |
| bus_we | input | 1 | 1 = write access, 0 = read access |
| bus_ofs | input | 2 | Register offset: 0 control, 1 address, 2 data, 3 key |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the selected offset (key reads 0) |
| irq | output | 1 | Write-complete interrupt |

## Verification
A key tracker stuck in the wrong state shows up in two ways. A write can start that should not, which raises busy (control bit 5) at the very next bus read and changes the array. Or a proper sequence starts nothing, which leaves busy low one cycle after the write-start. A wrong cycle counter shows as a busy window that is not WRITE_CYCLES long, measured on the first cycle it differs. A bad data-register update shows in the byte read back on the clock after the request. The flag logic shows its faults through `irq` and control bit 3 straight away, and through the array contents on the next read.

// File: rtl/nvb_pkg.sv
package nvb_pkg;

  typedef enum logic [1:0] {
    KS_IDLE    = 2'd0,
    KS_GOT55   = 2'd1,
    KS_GOTAA   = 2'd2,
    KS_WRITING = 2'd3
  } key_state_e;

  localparam logic [1:0] OFS_CTRL = 2'd0;
  localparam logic [1:0] OFS_ADDR = 2'd1;
  localparam logic [1:0] OFS_DATA = 2'd2;
  localparam logic [1:0] OFS_KEY  = 2'd3;

  localparam logic [7:0] KEY_FIRST  = 8'h55;
  localparam logic [7:0] KEY_SECOND = 8'hAA;

  localparam int B_RDGO  = 0;
  localparam int B_WREN  = 1;
  localparam int B_WRGO  = 2;
  localparam int B_DONE  = 3;
  localparam int B_IRQEN = 4;
  localparam int B_BUSY  = 5;

endpackage

// File: rtl/nvb_array.sv
module nvb_array #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] cells [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) cells[i] <= '0;
    end else if (we) begin
      cells[waddr] <= wdata;
    end
  end

  assign rdata = cells[raddr];
endmodule

// File: rtl/nvb_timer.sv
module nvb_timer #(
  parameter int CYC = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic finish
);
  localparam int CNT_W = (CYC > 1) ? $clog2(CYC) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CYC - 1);

  logic             busy_q;
  logic [CNT_W-1:0] cnt_q;

  function automatic logic at_last(input logic [CNT_W-1:0] c);
    return c == LAST;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (start) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
    end else if (busy_q) begin
      if (at_last(cnt_q)) begin
        busy_q <= 1'b0;
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign busy   = busy_q;
  assign finish = busy_q && at_last(cnt_q);
endmodule

// File: rtl/nvb_unlock.sv
module nvb_unlock
  import nvb_pkg::*;
#(
  parameter int MAX_GAP = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       acc,
  input  logic       key_wr,
  input  logic [7:0] key_val,
  input  logic       ctrl_wr,
  input  logic       go_bit,
  input  logic       wr_en,
  input  logic       wr_done,
  output key_state_e state,
  output logic       armed,
  output logic       wr_start
);
  localparam int GAP_W = $clog2(MAX_GAP + 2);
  localparam logic [GAP_W-1:0] GAP_LIM = GAP_W'(MAX_GAP);

  key_state_e       state_q, state_n;
  logic [GAP_W-1:0] gap_q, gap_n;

  function automatic logic gap_spent(input logic [GAP_W-1:0] g);
    return g == GAP_LIM;
  endfunction

  always_comb begin
    state_n  = state_q;
    gap_n    = '0;
    wr_start = 1'b0;
    case (state_q)
      KS_IDLE: begin
        if (key_wr && key_val == KEY_FIRST) state_n = KS_GOT55;
      end
      KS_GOT55: begin
        if (acc) begin
          if (key_wr && key_val == KEY_SECOND) state_n = KS_GOTAA;
          else                                 state_n = KS_IDLE;
        end else if (gap_spent(gap_q)) begin
          state_n = KS_IDLE;
        end else begin
          gap_n = gap_q + 1'b1;
        end
      end
      KS_GOTAA: begin
        if (acc) begin
          if (ctrl_wr && go_bit && wr_en) begin
            state_n  = KS_WRITING;
            wr_start = 1'b1;
          end else begin
            state_n = KS_IDLE;
          end
        end else if (gap_spent(gap_q)) begin
          state_n = KS_IDLE;
        end else begin
          gap_n = gap_q + 1'b1;
        end
      end
      KS_WRITING: begin
        if (wr_done) state_n = KS_IDLE;
      end
      default: state_n = KS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= KS_IDLE;
      gap_q   <= '0;
    end else begin
      state_q <= state_n;
      gap_q   <= gap_n;
    end
  end

  assign state = state_q;
  assign armed = (state_q == KS_GOTAA);
endmodule

// File: rtl/nvb_ctrl.sv
module nvb_ctrl
  import nvb_pkg::*;
#(
  parameter int ADDR_W       = 4,
  parameter int WRITE_CYCLES = 64,
  parameter int MAX_GAP      = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_sel,
  input  logic       bus_we,
  input  logic [1:0] bus_ofs,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic       irq
);
  localparam int DATA_W = 8;

  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic              wr_en_q, done_q, irq_en_q;

  logic       ctrl_wr, addr_wr, data_wr, key_wr;
  logic       rd_fire, ctrl_keep_done;
  logic       busy, wr_finish, wr_start, armed;
  logic [7:0] rd_word;
  logic [7:0] addr_ext;
  key_state_e key_state;

  assign ctrl_wr        = bus_sel && bus_we && (bus_ofs == OFS_CTRL);
  assign addr_wr        = bus_sel && bus_we && (bus_ofs == OFS_ADDR);
  assign data_wr        = bus_sel && bus_we && (bus_ofs == OFS_DATA);
  assign key_wr         = bus_sel && bus_we && (bus_ofs == OFS_KEY);
  assign rd_fire        = ctrl_wr && bus_wdata[B_RDGO] && !busy;
  assign ctrl_keep_done = bus_wdata[B_DONE];

  nvb_unlock #(.MAX_GAP(MAX_GAP)) u_unlock (
    .clk     (clk),
    .rst_n   (rst_n),
    .acc     (bus_sel),
    .key_wr  (key_wr),
    .key_val (bus_wdata),
    .ctrl_wr (ctrl_wr),
    .go_bit  (bus_wdata[B_WRGO]),
    .wr_en   (wr_en_q),
    .wr_done (wr_finish),
    .state   (key_state),
    .armed   (armed),
    .wr_start(wr_start)
  );

  nvb_timer #(.CYC(WRITE_CYCLES)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .start (wr_start),
    .busy  (busy),
    .finish(wr_finish)
  );

  nvb_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
    .clk  (clk),
    .rst_n(rst_n),
    .we   (wr_finish),
    .waddr(addr_q),
    .wdata(data_q),
    .raddr(addr_q),
    .rdata(rd_word)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      data_q <= '0;
    end else begin
      if (addr_wr && !busy) addr_q <= bus_wdata[ADDR_W-1:0];
      if (rd_fire)                data_q <= rd_word;
      else if (data_wr && !busy)  data_q <= bus_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_en_q  <= 1'b0;
      irq_en_q <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      if (ctrl_wr) begin
        wr_en_q  <= bus_wdata[B_WREN];
        irq_en_q <= bus_wdata[B_IRQEN];
      end
      if (wr_finish)                       done_q <= 1'b1;
      else if (ctrl_wr && !ctrl_keep_done) done_q <= 1'b0;
    end
  end

  always_comb begin
    addr_ext              = '0;
    addr_ext[ADDR_W-1:0]  = addr_q;
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_ofs)
      OFS_CTRL: begin
        bus_rdata[B_WREN]  = wr_en_q;
        bus_rdata[B_WRGO]  = busy;
        bus_rdata[B_DONE]  = done_q;
        bus_rdata[B_IRQEN] = irq_en_q;
        bus_rdata[B_BUSY]  = busy;
      end
      OFS_ADDR: bus_rdata = addr_ext;
      OFS_DATA: bus_rdata = data_q;
      default:  bus_rdata = '0;
    endcase
  end

  assign irq = done_q && irq_en_q;
endmodule

// File: rtl/nvb_ctrl_chk.sv
module nvb_ctrl_chk
  import nvb_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rd_fire,
  input logic [7:0]        rd_word,
  input logic [7:0]        data_q,
  input logic [ADDR_W-1:0] addr_q,
  input logic              busy,
  input logic              armed,
  input logic              wr_en_q,
  input key_state_e        key_state,
  input logic              wr_finish,
  input logic              done_q,
  input logic              irq_en_q,
  input logic              ctrl_wr,
  input logic              ctrl_keep_done,
  input logic              irq
);
  AST_RD_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    rd_fire |=> data_q == $past(rd_word)); // R2
  AST_START_NEEDS_KEYS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(armed)); // R4
  AST_START_NEEDS_WREN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(wr_en_q)); // R5
  AST_BUSY_MATCHES_FSM: assert property (@(posedge clk) disable iff (!rst_n)
    busy == (key_state == KS_WRITING)); // R6
  AST_FINISH_SETS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_finish |=> done_q && !busy); // R6
  AST_WREN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_q && !ctrl_wr |=> wr_en_q); // R7
  AST_BUSY_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(addr_q) && $stable(data_q)); // R8
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    done_q && !(ctrl_wr && !ctrl_keep_done) |=> done_q); // R9
  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> done_q && irq_en_q); // R10
endmodule

bind nvb_ctrl nvb_ctrl_chk #(.ADDR_W(ADDR_W)) i_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .rd_fire       (rd_fire),
  .rd_word       (rd_word),
  .data_q        (data_q),
  .addr_q        (addr_q),
  .busy          (busy),
  .armed         (armed),
  .wr_en_q       (wr_en_q),
  .key_state     (key_state),
  .wr_finish     (wr_finish),
  .done_q        (done_q),
  .irq_en_q      (irq_en_q),
  .ctrl_wr       (ctrl_wr),
  .ctrl_keep_done(ctrl_keep_done),
  .irq           (irq)
);

// File: tb/test_nvb_ctrl.sv
module test_nvb_ctrl;
  localparam int AW   = 4;
  localparam int WCYC = 8;
  localparam int NB   = 1 << AW;
  localparam logic [7:0] C_KEEP  = 8'h1A; // wr_en, done kept, irq_en
  localparam logic [7:0] C_READ  = 8'h1B;
  localparam logic [7:0] C_GO    = 8'h1E;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_sel = 1'b0, bus_we = 1'b0;
  logic [1:0] bus_ofs = 2'd0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       irq;

  int checks = 0, failures = 0;
  logic [7:0] exp_mem [NB];

  always #2.5 clk = ~clk;

  nvb_ctrl #(.ADDR_W(AW), .WRITE_CYCLES(WCYC), .MAX_GAP(1)) i_nvb_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_ofs(bus_ofs), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq));

  function automatic logic [7:0] pat(input int a, input int salt);
    return 8'((a * 37 + 11 + salt * 53) & 255);
  endfunction

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bwr(input logic [1:0] o, input logic [7:0] v);
    bus_sel = 1'b1; bus_we = 1'b1; bus_ofs = o; bus_wdata = v;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic brd(input logic [1:0] o, output logic [7:0] v);
    bus_sel = 1'b1; bus_we = 1'b0; bus_ofs = o;
    #1 v = bus_rdata;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic read_byte(input int a, output logic [7:0] v);
    bwr(2'd1, 8'(a));
    bwr(2'd0, C_READ);
    brd(2'd2, v);
  endtask

  task automatic wait_done(output int n);
    logic [7:0] v;
    n = 0;
    for (int k = 0; k < 100; k++) begin
      brd(2'd0, v);
      if (!v[5]) break;
      n++;
    end
  endtask

  task automatic write_byte(input int a, input logic [7:0] d, output int n);
    bwr(2'd1, 8'(a));
    bwr(2'd2, d);
    bwr(2'd0, C_KEEP);
    bwr(2'd3, 8'h55);
    bwr(2'd3, 8'hAA);
    bwr(2'd0, C_GO);
    wait_done(n);
    exp_mem[a] = d;
  endtask

  // failed key sequences: no write may start (R4)
  task automatic attempt(input int mode, input int a);
    logic [7:0] v;
    bwr(2'd1, 8'(a));
    bwr(2'd2, 8'hE7);
    bwr(2'd0, C_KEEP);
    case (mode)
      0: begin bwr(2'd3, 8'h56); bwr(2'd3, 8'hAA); end
      1: begin bwr(2'd3, 8'hAA); bwr(2'd3, 8'h55); end
      2: begin bwr(2'd3, 8'h55); idle(2); bwr(2'd3, 8'hAA); end
      3: begin bwr(2'd3, 8'h55); bwr(2'd3, 8'hAA); brd(2'd1, v); end
      4: begin bwr(2'd3, 8'h55); bwr(2'd3, 8'hAA); idle(2); end
      default: begin bwr(2'd3, 8'h55); bwr(2'd1, 8'(a)); bwr(2'd3, 8'hAA); end
    endcase
    bwr(2'd0, C_GO);
    brd(2'd0, v);
    chk(v[5] == 1'b0, $sformatf("R4 busy mode %0d", mode), v[5], 0);
    idle(WCYC + 2);
    read_byte(a, v);
    chk(v == exp_mem[a], $sformatf("R4 array mode %0d", mode), v, exp_mem[a]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [7:0] v;
    int n;
    for (int i = 0; i < NB; i++) exp_mem[i] = 8'h00;
    idle(3);
    rst_n = 1'b1;
    idle(1);

    // R1 reset state
    brd(2'd0, v); chk(v == 8'h00, "R1 ctrl", v, 0);
    brd(2'd1, v); chk(v == 8'h00, "R1 addr", v, 0);
    brd(2'd2, v); chk(v == 8'h00, "R1 data", v, 0);
    chk(irq == 1'b0, "R1 irq", irq, 0);

    // R6/R2 sweep over every address
    for (int a = 0; a < NB; a++) begin
      write_byte(a, pat(a, 0), n);
      chk(n == WCYC, $sformatf("R6 cycles addr %0d", a), n, WCYC);
      brd(2'd0, v);
      chk(v[3] == 1'b1 && v[2] == 1'b0, "R6 flag set, active clear", v, 8'h08);
      chk(v[1] == 1'b1, "R7 wr_en kept by hardware", v[1], 1);
      chk(irq == 1'b1, "R10 irq with enable", irq, 1);
    end
    for (int a = 0; a < NB; a++) begin
      read_byte(a, v);
      chk(v == exp_mem[a], $sformatf("R2 readback %0d", a), v, exp_mem[a]);
    end
    brd(2'd0, v); chk(v[0] == 1'b0, "R2 read bit self-clears", v[0], 0);

    // R3 data register holding
    read_byte(3, v);
    bwr(2'd1, 8'd5);
    idle(4);
    brd(2'd2, v); chk(v == exp_mem[3], "R3 hold over address change", v, exp_mem[3]);
    bwr(2'd2, 8'h5A);
    brd(2'd2, v); chk(v == 8'h5A, "R3 CPU write", v, 8'h5A);

    // R9 sticky flag, R10 interrupt gating
    bwr(2'd0, C_KEEP);
    idle(20);
    brd(2'd0, v); chk(v[3] == 1'b1, "R9 flag kept", v[3], 1);
    bwr(2'd0, 8'h0A);
    chk(irq == 1'b0, "R10 irq off without enable", irq, 0);
    bwr(2'd0, 8'h12);
    brd(2'd0, v); chk(v[3] == 1'b0, "R9 flag cleared by 0", v[3], 0);
    chk(irq == 1'b0, "R10 irq off without flag", irq, 0);

    // R4 failed sequences
    for (int m = 0; m < 6; m++) attempt(m, m + 2);

    // R4 one idle cycle between steps is accepted
    bwr(2'd1, 8'd9);
    bwr(2'd2, 8'h3C);
    bwr(2'd0, C_KEEP);
    bwr(2'd3, 8'h55); idle(1);
    bwr(2'd3, 8'hAA); idle(1);
    bwr(2'd0, C_GO);
    wait_done(n);
    exp_mem[9] = 8'h3C;
    chk(n == WCYC, "R4 gap of one accepted", n, WCYC);
    read_byte(9, v); chk(v == 8'h3C, "R4 gap write data", v, 8'h3C);

    // R11 no fresh keys -> no second write
    bwr(2'd2, 8'h99);
    bwr(2'd0, C_GO);
    brd(2'd0, v); chk(v[5] == 1'b0, "R11 no write without keys", v[5], 0);
    idle(WCYC + 2);
    read_byte(9, v); chk(v == 8'h3C, "R11 array unchanged", v, 8'h3C);

    // R5 wr_en must be set beforehand
    bwr(2'd1, 8'd4);
    bwr(2'd2, 8'h81);
    bwr(2'd0, 8'h18);
    bwr(2'd3, 8'h55);
    bwr(2'd3, 8'hAA);
    bwr(2'd0, C_GO);
    brd(2'd0, v); chk(v[5] == 1'b0, "R5 no write without prior enable", v[5], 0);
    idle(WCYC + 2);
    read_byte(4, v); chk(v == exp_mem[4], "R5 array unchanged", v, exp_mem[4]);

    // R7 clearing wr_en mid-write does not abort; R8 busy ignores bus
    bwr(2'd1, 8'd2);
    bwr(2'd2, 8'hD4);
    bwr(2'd0, C_KEEP);
    bwr(2'd3, 8'h55);
    bwr(2'd3, 8'hAA);
    bwr(2'd0, C_GO);
    bwr(2'd0, 8'h18);
    bwr(2'd1, 8'd11);
    bwr(2'd2, 8'h77);
    bwr(2'd0, 8'h19);
    wait_done(n);
    exp_mem[2] = 8'hD4;
    chk(n == WCYC - 4, "R7 write ran to end", n, WCYC - 4);
    brd(2'd1, v); chk(v == 8'd2, "R8 address ignored while busy", v, 2);
    brd(2'd2, v); chk(v == 8'hD4, "R8 data/read ignored while busy", v, 8'hD4);
    brd(2'd0, v); chk(v[1] == 1'b0 && v[3] == 1'b1, "R7 wr_en stays cleared, flag set", v, 8'h18);
    read_byte(2, v); chk(v == 8'hD4, "R7 byte committed", v, 8'hD4);
    read_byte(11, v); chk(v == exp_mem[11], "R8 other byte untouched", v, exp_mem[11]);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule